// File: doc/BRIEF.md
# Decimating FIR Filter

This block lowers the sample rate of a 16-bit signed stream by a fixed integer factor. It applies a direct-form lowpass FIR filter before the rate drops, so energy above the new Nyquist band does not alias. The filter sum is formed only for the input samples that survive decimation. The in-between filter outputs are never computed, which divides the multiply-accumulate work by the decimation factor.

Samples enter through a valid/ready handshake. A phase counter marks every DECIM-th accepted sample as a kept one. The kept sample starts a sequential pass over the taps that uses one shared multiplier. The block holds its input ready low for the length of the pass, so the delay line stays frozen. The result is rounded and saturated, and it leaves as a one-cycle valid pulse.

The coefficient array is loaded through a simple write port while the block is idle. The coefficients are Q15 values, so a set whose sum is 32768 gives unity passband gain. The user designs them as a lowpass with its cutoff at pi/DECIM.

Top module: `fir_decimator`

## Requirements
- R1: The block produces exactly one output for the accepted inputs numbered 0, DECIM, 2·DECIM, … since reset, and none for any other input. The phase counter stays below DECIM.
- R2: For kept input k, out_data = floor((Σ_{m=0}^{TAPS-1} h[m]·x[k-m] + 2^14) / 2^15), saturated as in R3. Here h[m] is the coefficient at write address m, and x[k-m] is the input accepted m samples earlier (index 0 is the newest).
- R3: The rounded result is clamped to the range -32768 … 32767.
- R4: Reset is synchronous and active high. After reset, out_valid is 0, in_ready is 1, the phase is 0 and every delay-line sample is 0, so history from before the first input counts as zero.
- R5: After a kept input is accepted, in_ready is low for exactly TAPS consecutive cycles. After a non-kept input, in_ready stays high. An input offered while in_ready is low is not taken.
- R6: out_valid rises on the clock edge TAPS+2 edges after the edge that accepted the kept input.
- R7: out_valid is high for a single cycle per output.
- R8: coef_we=1 writes coef_wdata into coefficient coef_addr on the clock edge. Addresses ≥ TAPS are ignored. Passes that start after the write use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | CA_W | Coefficient index (tap m) |
| coef_wdata | input | COEF_W | Q15 signed coefficient value |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | DATA_W | Rounded, saturated decimated sample |

## Verification
The bench builds the block with TAPS=5 and DECIM=3. At this size an impulse placed at every position across two full decimation periods hits every tap at every phase. Run lengths of the ready stall, output latency and output count can all be checked on every pass.

Full-scale coefficients and inputs drive both saturation limits. A single unit tap probes rounding at exactly half and on either side of it, for both signs. A pseudo-random stream is run with gaps, with back-to-back inputs, and after a coefficient rewrite.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  // Control tag that travels with each tap product through the MAC pipeline.
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } mac_tag_t;
endpackage

// File: rtl/fdec_ctrl.sv
module fdec_ctrl #(
  parameter int TAPS  = 16,
  parameter int DECIM = 4,
  localparam int TAP_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    shift_en,
  output logic [TAP_W-1:0]        rd_addr,
  output fdec_pkg::mac_tag_t      issue_tag,
  output logic                    busy,
  output logic [PH_W-1:0]         phase
);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAPS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DECIM - 1);

  logic             busy_q;
  logic [TAP_W-1:0] tap_q;
  logic [PH_W-1:0]  phase_q;
  logic             accept;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;
  assign shift_en = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tap_q   <= '0;
      phase_q <= '0;
    end else begin
      if (accept) begin
        phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        if (phase_q == '0) begin
          busy_q <= 1'b1;
          tap_q  <= '0;
        end
      end
      if (busy_q) begin
        if (tap_q == TAP_LAST) busy_q <= 1'b0;
        else                   tap_q  <= tap_q + 1'b1;
      end
    end
  end

  assign rd_addr         = tap_q;
  assign issue_tag.vld   = busy_q;
  assign issue_tag.first = (tap_q == '0);
  assign issue_tag.last  = (tap_q == TAP_LAST);
  assign busy            = busy_q;
  assign phase           = phase_q;
endmodule

// File: rtl/fdec_delay_line.sv
module fdec_delay_line #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  localparam int TAP_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic [TAP_W-1:0]         rd_addr,
  output logic signed [DATA_W-1:0] rd_data
);
  logic signed [DATA_W-1:0] line_q [TAPS];

  always_ff @(posedge clk) begin
    if (rst)           line_q[0] <= '0;
    else if (shift_en) line_q[0] <= din;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           line_q[i] <= '0;
      else if (shift_en) line_q[i] <= line_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= line_q[rd_addr];
  end
endmodule

// File: rtl/fdec_coef_bank.sv
module fdec_coef_bank #(
  parameter int COEF_W = 16,
  parameter int TAPS   = 16,
  localparam int TAP_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [TAP_W-1:0]         waddr,
  input  logic signed [COEF_W-1:0] wdata,
  input  logic [TAP_W-1:0]         raddr,
  output logic signed [COEF_W-1:0] rdata
);
  logic signed [COEF_W-1:0] mem [TAPS];

  // Single write port plus registered read port, RAM-inferable.
  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < TAPS)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fdec_mac.sv
module fdec_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 16,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fdec_pkg::mac_tag_t       tag_in,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + ((TAPS > 1) ? $clog2(TAPS) : 0);
  localparam int EXT_W  = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (FRAC - 1);
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

  logic signed [PROD_W-1:0] prod_q;
  fdec_pkg::mac_tag_t       ptag_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  sum;
  logic signed [EXT_W-1:0]  rnd;
  logic signed [EXT_W-1:0]  shf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptag_q <= '0;
      prod_q <= '0;
    end else begin
      ptag_q <= tag_in;
      prod_q <= PROD_W'(sample) * PROD_W'(coef);
    end
  end

  always_comb begin
    sum = (ptag_q.first ? ACC_W'(0) : acc_q) + ACC_W'(prod_q);
    rnd = EXT_W'(sum) + HALF;
    shf = rnd >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (ptag_q.vld) begin
        acc_q <= sum;
        if (ptag_q.last) begin
          out_valid <= 1'b1;
          if (shf > MAXV)      out_data <= MAXV[DATA_W-1:0];
          else if (shf < MINV) out_data <= MINV[DATA_W-1:0];
          else                 out_data <= shf[DATA_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/fir_decimator.sv
module fir_decimator #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 16,
  parameter int DECIM  = 4,
  parameter int FRAC   = 15,
  localparam int CA_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     coef_we,
  input  logic [CA_W-1:0]          coef_addr,
  input  logic signed [COEF_W-1:0] coef_wdata,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic                     shift_en;
  logic [CA_W-1:0]          tap;
  logic                     busy;
  logic [PH_W-1:0]          phase;
  fdec_pkg::mac_tag_t       issue_tag;
  fdec_pkg::mac_tag_t       rd_tag_q;
  logic signed [DATA_W-1:0] smp_rd;
  logic signed [COEF_W-1:0] coef_rd;

  fdec_ctrl #(.TAPS(TAPS), .DECIM(DECIM)) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .shift_en(shift_en), .rd_addr(tap), .issue_tag(issue_tag),
    .busy(busy), .phase(phase)
  );

  fdec_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) i_line (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(in_data),
    .rd_addr(tap), .rd_data(smp_rd)
  );

  fdec_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS)) i_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr(tap), .rdata(coef_rd)
  );

  // Tag delayed to line up with the registered reads.
  always_ff @(posedge clk) begin
    if (rst) rd_tag_q <= '0;
    else     rd_tag_q <= issue_tag;
  end

  fdec_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .FRAC(FRAC)) i_mac (
    .clk(clk), .rst(rst), .tag_in(rd_tag_q), .sample(smp_rd), .coef(coef_rd),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/fdec_checker.sv
module fdec_checker #(
  parameter int TAPS  = 16,
  parameter int DECIM = 4,
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic [PH_W-1:0] phase
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)            low_run <= 0;
    else if (!in_ready) low_run <= low_run + 1;
    else                low_run <= 0;
  end

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && phase == '0) |=> !in_ready);

  // R5
  ready_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && phase != '0) |=> in_ready);

  // R5
  ready_len_chk: assert property (@(posedge clk) disable iff (rst)
    low_run <= TAPS);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(phase) < DECIM);

  // R4
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid && phase == '0));
endmodule

bind fir_decimator fdec_checker #(.TAPS(TAPS), .DECIM(DECIM)) i_fdec_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .phase(phase)
);

// File: tb/test_fir_decimator.sv
module test_fir_decimator;
  localparam int TAPS  = 5;
  localparam int DECIM = 3;
  localparam int CA_W  = $clog2(TAPS);
  localparam int HMAX  = 256;

  logic clk = 0;
  logic rst = 1;
  logic coef_we = 0;
  logic [CA_W-1:0] coef_addr = '0;
  logic signed [15:0] coef_wdata = '0;
  logic in_valid = 0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  fir_decimator #(.DATA_W(16), .COEF_W(16), .TAPS(TAPS), .DECIM(DECIM), .FRAC(15)) i_fir_decimator (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int hc [TAPS];
  int hist [HMAX];
  int nacc = 0;
  int exp_v [HMAX];
  int exp_c [HMAX];
  string exp_t [HMAX];
  int wr = 0;
  int rd = 0;
  int low_run = 0;
  string grp_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int model_out(input int k);
    longint acc = 0;
    longint r;
    for (int m = 0; m < TAPS; m++)
      if (k - m >= 0) acc += longint'(hc[m]) * longint'(hist[k-m]);
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic model_accept(input int v, input int edge_c);
    hist[nacc] = v;
    if (nacc % DECIM == 0) begin
      exp_v[wr] = model_out(nacc);
      exp_c[wr] = edge_c + TAPS + 2;
      exp_t[wr] = (exp_v[wr] == 32767 || exp_v[wr] == -32768) ? "R3" : grp_tag;
      wr++;
    end
    nacc++;
  endtask

  // Output and ready monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (rd >= wr) check(0, "R1 unexpected output", int'(out_data), 0);
        else begin
          check(int'(out_data) == exp_v[rd], exp_t[rd], int'(out_data), exp_v[rd]);
          check(cyc == exp_c[rd], "R6 latency", cyc, exp_c[rd]);
          rd++;
        end
      end
      if (!in_ready) low_run++;
      else if (low_run != 0) begin
        check(low_run == TAPS, "R5 stall length", low_run, TAPS);
        low_run = 0;
      end
    end
  end

  task automatic do_reset();
    rst = 1;
    in_valid = 0;
    repeat (3) @(negedge clk);
    nacc = 0; wr = 0; rd = 0; low_run = 0;
    rst = 0;
    @(negedge clk);
    check(in_ready == 1'b1, "R4 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R4 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic write_coef(input int m, input int v);
    coef_we = 1; coef_addr = CA_W'(m); coef_wdata = 16'(v);
    @(negedge clk);
    coef_we = 0;
    if (m < TAPS) hc[m] = v;
  endtask

  task automatic send(input int v, input int gap);
    in_data = 16'(v);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    model_accept(v, cyc + 1);
    @(negedge clk);
    in_valid = 0;
    in_data = 16'sh5A5A;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    repeat (TAPS + 6) @(negedge clk);
    check(rd == wr, "R1 outputs delivered", rd, wr);
    check(wr == (nacc + DECIM - 1) / DECIM, "R1 output count", wr, (nacc + DECIM - 1) / DECIM);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    // Write all coefficients once; the bank keeps them through reset.
    @(negedge clk);
    write_coef(0, 1200); write_coef(1, -3400); write_coef(2, 5600);
    write_coef(3, -7800); write_coef(4, 9000);
    do_reset();

    // R2 / R4: impulse at every position over two decimation periods.
    grp_tag = "R2";
    for (int p = 0; p < 2 * DECIM; p++) begin
      do_reset();
      for (int i = 0; i < 14; i++) send((i == p) ? 20000 : 0, p % 2);
      drain();
    end

    // R4: the first output uses zero history.
    grp_tag = "R4";
    do_reset();
    send(-31000, 0);
    drain();

    // R2: pseudo-random stream, back-to-back and gapped.
    grp_tag = "R2";
    do_reset();
    for (int i = 0; i < 60; i++) begin
      lfsr = step(lfsr);
      send(int'($signed(lfsr)), (i % 7 == 3) ? 2 : 0);
    end
    drain();

    // R8: rewrite coefficients while idle and keep streaming; an out-of-range write is dropped.
    grp_tag = "R8";
    write_coef(0, -20000); write_coef(1, 15000); write_coef(2, 300);
    write_coef(3, 4096); write_coef(4, -1);
    write_coef(7, 32767);
    for (int i = 0; i < 30; i++) begin
      lfsr = step(lfsr);
      send(int'($signed(lfsr)), 0);
    end
    drain();

    // R3: both saturation limits.
    for (int m = 0; m < TAPS; m++) write_coef(m, 32767);
    do_reset();
    for (int i = 0; i < 9; i++) send(32767, 0);
    for (int i = 0; i < 9; i++) send(-32768, 0);
    drain();

    // R2: rounding at and around one half, both signs.
    write_coef(0, 1);
    for (int m = 1; m < TAPS; m++) write_coef(m, 0);
    do_reset();
    send(16384, 0); send(0, 0); send(0, 0);
    send(16383, 0); send(0, 0); send(0, 0);
    send(-16384, 0); send(0, 0); send(0, 0);
    send(-16385, 0); send(0, 0); send(0, 0);
    send(32767, 0);
    drain();
    check(exp_v[0] == 1 && exp_v[1] == 0 && exp_v[2] == 0 && exp_v[3] == -1,
          "R2 rounding model", exp_v[3], -1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule